// File: doc/BRIEF.md
# Hierarchical Interrupt Status Controller

This block collects interrupt events into two levels of byte-wide registers that a processor reaches over an 8-bit bus. The lower level holds two error registers and one general-purpose register. Each of these accumulates single-bit event pulses. A fourth lower-level register captures an 8-bit time-slot value that arrives with a strobe. The upper level is a main status byte. Four of its bits summarise the lower-level registers. One bit is a ready flag that can raise an interrupt. Three bits are status-only flags that never do.

A mask register decides which sources may drive a level-active interrupt request. An interrupt routine reads the main byte to find the cause, then reads the lower-level register it points to. That read clears the register and its summary bit. While a mask write is in progress the request is held low. When the write ends the request is evaluated again, so an edge-sensitive interrupt controller sees a new edge if work is still pending.

Top module: `irq_hier_ctrl`

## Requirements
- R1: Byte addresses are 0 main status, 1 mask, 2 error register 1, 3 error register 2, 4 general-purpose, 5 time-slot value; other addresses read 0. Read data is registered and is valid from the clock edge that samples the one-cycle read strobe. After reset the mask reads 0x1F and every other register, and the request, read 0.
- R2: Error 1, error 2 and general-purpose registers OR each incoming event bit into the stored value. Main bits 0, 1 and 2 are set while error 1, error 2 and general-purpose are non-zero, respectively.
- R3: Reading an error or general-purpose register returns its contents and clears both the register and its main summary bit.
- R4: An event arriving in the same cycle its register is read stays pending after the read.
- R5: A time-slot strobe stores the 8-bit value and sets main bit 3. Reading the time-slot register returns the value and clears only main bit 3; the stored value remains.
- R6: Mask bits 0 to 3 block the sources behind main bits 0 to 3, and mask bit 4 blocks the ready interrupt; a 1 blocks. A masked source still shows in the main byte.
- R7: The request rises one cycle after an unmasked source becomes pending. It stays high, without a drop, until no unmasked source remains, including when one source is serviced while another is still pending.
- R8: While the bus writes the mask address the request is low. One cycle after the write ends it reflects pending sources under the new mask.
- R9: A ready-set input sets main bit 4. A 0-to-1 change of that flag makes a ready interrupt pending. Reading the main byte clears the pending interrupt but not the flag. Only the ready-clear input clears the flag.
- R10: Main bit 5 is a no-further-connections flag set and cleared by its own inputs. Bits 6 and 7 follow the stream-configured and PLL-locked inputs one cycle later. None of these three raises the request.
- R11: Processor writes to any address other than the mask change no status flag or register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register byte address |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wr | input | 1 | Write access, high for its whole duration |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ev_err1 | input | 8 | Event pulses for error register 1 |
| ev_err2 | input | 8 | Event pulses for error register 2 |
| ev_gp | input | 8 | Event pulses for the general-purpose register |
| ts_stb | input | 1 | Time-slot value strobe |
| ts_val | input | 8 | Time-slot value |
| ctl_rdy_set | input | 1 | Internal controller sets the ready flag |
| ctl_rdy_clr | input | 1 | Internal controller clears the ready flag |
| ctl_nfc_set | input | 1 | Sets the no-further-connections flag |
| ctl_nfc_clr | input | 1 | Clears the no-further-connections flag |
| ctl_stream | input | 1 | Stream connection configured, level |
| ctl_pll_lock | input | 1 | PLL locked, level |
| irq | output | 1 | Level-active interrupt request |

## Verification
The bench uses the default parameters, a data width of 8 and an address width of 3. This covers the full byte patterns on every lower-level register, including the mixed bit patterns that show the OR accumulation. The 3-bit address also reaches the two unused addresses 6 and 7. Directed scenarios cover the cycle-level corners: an event landing on the read cycle, a request that must not drop while a second source is pending, and a mask write held for several cycles.

// File: rtl/irq_hier_pkg.sv
package irq_hier_pkg;
  localparam int ADR_MAIN = 0;
  localparam int ADR_MASK = 1;
  localparam int ADR_ERR1 = 2;
  localparam int ADR_ERR2 = 3;
  localparam int ADR_GP   = 4;
  localparam int ADR_TSV  = 5;
  // number of maskable sources: four summaries plus ready
  localparam int NSRC     = 5;
  localparam int NSEC     = 3;
  localparam int MAIN_W   = 8;
  localparam int B_RDY    = 4;
  localparam int B_NFC    = 5;
  localparam int B_STR    = 6;
  localparam int B_PLL    = 7;
endpackage

// File: rtl/irq_sticky_reg.sv
module irq_sticky_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o,
  output logic         any_o
);
  logic [W-1:0] q;
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (clr_i ? '0 : q) | set_i;   // set beats clear-on-read
  end
  assign q_o   = q;
  assign any_o = |q;
endmodule

// File: rtl/irq_tsv_reg.sv
module irq_tsv_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stb_i,
  input  logic [W-1:0] val_i,
  input  logic         clr_i,
  output logic [W-1:0] val_o,
  output logic         flag_o
);
  logic [W-1:0] val_q;
  logic         new_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
      new_q <= 1'b0;
    end else begin
      if (stb_i) val_q <= val_i;
      new_q <= stb_i | (new_q & ~clr_i);
    end
  end
  assign val_o  = val_q;
  assign flag_o = new_q;
endmodule

// File: rtl/irq_main_ctl.sv
module irq_main_ctl
  import irq_hier_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        sum_i,
  input  logic              rdy_set_i,
  input  logic              rdy_clr_i,
  input  logic              nfc_set_i,
  input  logic              nfc_clr_i,
  input  logic              str_i,
  input  logic              pll_i,
  input  logic              main_rd_i,
  input  logic              mask_wr_i,
  input  logic [NSRC-1:0]   mask_d_i,
  output logic [MAIN_W-1:0] main_o,
  output logic [NSRC-1:0]   mask_o,
  output logic [NSRC-1:0]   src_o,
  output logic              irq_o
);
  logic            rdy_q, rdy_pend_q, nfc_q, str_q, pll_q, irq_q;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] src;
  logic            rdy_rise;

  assign rdy_rise = rdy_set_i & ~rdy_q;
  assign src      = {rdy_pend_q, sum_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q      <= 1'b0;
      rdy_pend_q <= 1'b0;
      nfc_q      <= 1'b0;
      str_q      <= 1'b0;
      pll_q      <= 1'b0;
      mask_q     <= '1;
      irq_q      <= 1'b0;
    end else begin
      rdy_q      <= rdy_set_i | (rdy_q & ~rdy_clr_i);
      rdy_pend_q <= rdy_rise | (rdy_pend_q & ~main_rd_i);
      nfc_q      <= nfc_set_i | (nfc_q & ~nfc_clr_i);
      str_q      <= str_i;
      pll_q      <= pll_i;
      if (mask_wr_i) mask_q <= mask_d_i;
      irq_q      <= mask_wr_i ? 1'b0 : |(src & ~mask_q);
    end
  end

  always_comb begin
    main_o        = '0;
    main_o[3:0]   = sum_i;
    main_o[B_RDY] = rdy_q;
    main_o[B_NFC] = nfc_q;
    main_o[B_STR] = str_q;
    main_o[B_PLL] = pll_q;
  end

  assign mask_o = mask_q;
  assign src_o  = src;
  assign irq_o  = irq_q;
endmodule

// File: rtl/irq_hier_ctrl.sv
module irq_hier_ctrl
  import irq_hier_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] ev_err1,
  input  logic [DW-1:0] ev_err2,
  input  logic [DW-1:0] ev_gp,
  input  logic          ts_stb,
  input  logic [DW-1:0] ts_val,
  input  logic          ctl_rdy_set,
  input  logic          ctl_rdy_clr,
  input  logic          ctl_nfc_set,
  input  logic          ctl_nfc_clr,
  input  logic          ctl_stream,
  input  logic          ctl_pll_lock,
  output logic          irq
);
  localparam int NADR = 1 << AW;

  logic [NADR-1:0]         rd_hit;
  logic                    mask_wr;
  logic [NSEC-1:0][DW-1:0] sec_set, sec_q;
  logic [NSEC-1:0]         sec_clr, sec_any;
  logic [DW-1:0]           tsv_q;
  logic                    tsv_new;
  logic [MAIN_W-1:0]       main_v;
  logic [NSRC-1:0]         mask_v, src_v;
  logic [DW-1:0]           rd_mux;
  logic [DW-1:0]           rdata_q;

  always_comb begin
    rd_hit = '0;
    if (bus_rd) rd_hit[bus_addr] = 1'b1;
  end
  assign mask_wr = bus_wr && (bus_addr == AW'(ADR_MASK));

  assign sec_set[0] = ev_err1;
  assign sec_set[1] = ev_err2;
  assign sec_set[2] = ev_gp;

  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    assign sec_clr[g] = rd_hit[ADR_ERR1 + g];
    irq_sticky_reg #(.W(DW)) u_reg (
      .clk(clk), .rst(rst), .set_i(sec_set[g]), .clr_i(sec_clr[g]),
      .q_o(sec_q[g]), .any_o(sec_any[g])
    );
  end

  irq_tsv_reg #(.W(DW)) u_tsv (
    .clk(clk), .rst(rst), .stb_i(ts_stb), .val_i(ts_val),
    .clr_i(rd_hit[ADR_TSV]), .val_o(tsv_q), .flag_o(tsv_new)
  );

  irq_main_ctl u_main (
    .clk(clk), .rst(rst),
    .sum_i({tsv_new, sec_any[2], sec_any[1], sec_any[0]}),
    .rdy_set_i(ctl_rdy_set), .rdy_clr_i(ctl_rdy_clr),
    .nfc_set_i(ctl_nfc_set), .nfc_clr_i(ctl_nfc_clr),
    .str_i(ctl_stream), .pll_i(ctl_pll_lock),
    .main_rd_i(rd_hit[ADR_MAIN]),
    .mask_wr_i(mask_wr), .mask_d_i(bus_wdata[NSRC-1:0]),
    .main_o(main_v), .mask_o(mask_v), .src_o(src_v), .irq_o(irq)
  );

  always_comb begin
    rd_mux = '0;
    case (int'(bus_addr))
      ADR_MAIN: rd_mux = DW'(main_v);
      ADR_MASK: rd_mux = DW'(mask_v);
      ADR_ERR1: rd_mux = sec_q[0];
      ADR_ERR2: rd_mux = sec_q[1];
      ADR_GP:   rd_mux = sec_q[2];
      ADR_TSV:  rd_mux = tsv_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/irq_hier_chk.sv
module irq_hier_chk
  import irq_hier_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_rd,
  input logic            bus_wr,
  input logic [DW-1:0]   ev_err1,
  input logic            irq,
  input logic [DW-1:0]   err1_q,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] src_q
);
  logic mask_wr, rd_e1;
  assign mask_wr = bus_wr && (bus_addr == AW'(ADR_MASK));
  assign rd_e1   = bus_rd && (bus_addr == AW'(ADR_ERR1));

  assert_mask_write_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    mask_wr |=> !irq);
  assert_all_masked_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (&mask_q) |=> !irq);
  assert_read_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_e1 && ev_err1 == '0) |=> err1_q == '0);
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (ev_err1 != '0) |=> ((err1_q & $past(ev_err1)) == $past(ev_err1)));
  assert_no_source_no_req_R10: assert property (@(posedge clk) disable iff (rst)
    (src_q == '0) |=> !irq);
  assert_req_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (irq && !mask_wr && ((src_q & ~mask_q) != '0)) |=> irq);
endmodule

bind irq_hier_ctrl irq_hier_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .ev_err1(ev_err1), .irq(irq), .err1_q(sec_q[0]), .mask_q(mask_v), .src_q(src_v)
);

// File: tb/tb_irq_hier_ctrl.sv
module tb_irq_hier_ctrl;
  localparam int CLK_P = 10;
  localparam int DW = 8;
  localparam int AW = 3;

  logic clk = 0, rst = 1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_rd = 0, bus_wr = 0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic [DW-1:0] ev_err1 = '0, ev_err2 = '0, ev_gp = '0, ts_val = '0;
  logic ts_stb = 0, ctl_rdy_set = 0, ctl_rdy_clr = 0, ctl_nfc_set = 0, ctl_nfc_clr = 0;
  logic ctl_stream = 0, ctl_pll_lock = 0, irq;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_hier_ctrl #(.DW(DW), .AW(AW)) dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    @(negedge clk); bus_addr = AW'(a); bus_rd = 1;
    @(negedge clk); bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d, input int ncyc);
    @(negedge clk); bus_addr = AW'(a); bus_wdata = d; bus_wr = 1;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (a == 1) check("R8 irq low during mask write", irq, 0);
    end
    bus_wr = 0;
    @(negedge clk);
  endtask

  task automatic pulse_err1(input logic [DW-1:0] v);
    @(negedge clk); ev_err1 = v; @(negedge clk); ev_err1 = '0;
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    check("R1 irq after reset", irq, 0);
    rd(1, d); check("R1 mask reset", d, 8'h1F);
    rd(0, d); check("R1 main reset", d, 0);
    rd(6, d); check("R1 unused addr", d, 0);
  endtask

  task automatic t_masked_pending;
    logic [DW-1:0] d;
    pulse_err1(8'h05); pulse_err1(8'h30);
    @(negedge clk); check("R6 masked no irq", irq, 0);
    rd(0, d); check("R6 R2 masked still visible", d, 8'h01);
    wr(1, 8'h00, 2);
    check("R8 R7 irq after mask write", irq, 1);
    rd(2, d); check("R2 R3 err1 accumulated", d, 8'h35);
    @(negedge clk); check("R3 R7 irq drops", irq, 0);
    rd(0, d); check("R3 summary cleared", d, 8'h00);
    rd(2, d); check("R3 err1 cleared", d, 8'h00);
  endtask

  task automatic t_set_wins;
    logic [DW-1:0] d;
    pulse_err1(8'h01);
    @(negedge clk); bus_addr = 3'd2; bus_rd = 1; ev_err1 = 8'h80;
    @(negedge clk); bus_rd = 0; ev_err1 = '0;
    check("R4 read value", bus_rdata, 8'h01);
    check("R4 irq stays", irq, 1);
    rd(2, d); check("R4 new event kept", d, 8'h80);
    @(negedge clk);
  endtask

  task automatic t_no_glitch;
    logic [DW-1:0] d;
    @(negedge clk); ev_err2 = 8'h02; ev_gp = 8'h40;
    @(negedge clk); ev_err2 = '0; ev_gp = '0;
    @(negedge clk); check("R7 irq up", irq, 1);
    rd(0, d); check("R2 main err2 gp", d, 8'h06);
    rd(3, d); check("R3 err2 value", d, 8'h02);
    @(negedge clk); check("R7 irq held with gp pending", irq, 1);
    @(negedge clk); check("R7 irq held 2", irq, 1);
    rd(4, d); check("R3 gp value", d, 8'h40);
    @(negedge clk); check("R7 irq released", irq, 0);
  endtask

  task automatic t_tsv;
    logic [DW-1:0] d;
    @(negedge clk); ts_stb = 1; ts_val = 8'hA5;
    @(negedge clk); ts_stb = 0;
    @(negedge clk); check("R5 irq on tsv", irq, 1);
    rd(0, d); check("R5 main bit3", d, 8'h08);
    rd(5, d); check("R5 tsv value", d, 8'hA5);
    rd(0, d); check("R5 bit3 cleared", d, 8'h00);
    rd(5, d); check("R5 value kept", d, 8'hA5);
    check("R5 irq low", irq, 0);
  endtask

  task automatic t_ready;
    logic [DW-1:0] d;
    @(negedge clk); ctl_rdy_set = 1;
    @(negedge clk); ctl_rdy_set = 0;
    @(negedge clk); check("R9 ready irq", irq, 1);
    rd(0, d); check("R9 main rdy", d, 8'h10);
    @(negedge clk); check("R9 irq cleared by main read", irq, 0);
    rd(0, d); check("R9 flag stays", d, 8'h10);
    @(negedge clk); ctl_rdy_clr = 1;
    @(negedge clk); ctl_rdy_clr = 0;
    rd(0, d); check("R9 flag cleared", d, 8'h00);
  endtask

  task automatic t_status_only;
    logic [DW-1:0] d;
    @(negedge clk); ctl_nfc_set = 1; ctl_stream = 1; ctl_pll_lock = 1;
    @(negedge clk); ctl_nfc_set = 0;
    @(negedge clk); @(negedge clk);
    check("R10 no irq from status", irq, 0);
    rd(0, d); check("R10 status bits", d, 8'hE0);
    wr(0, 8'h00, 1); wr(2, 8'hFF, 1);
    rd(0, d); check("R11 main unchanged by write", d, 8'hE0);
    rd(2, d); check("R11 err1 unchanged by write", d, 8'h00);
    @(negedge clk); ctl_nfc_clr = 1; ctl_pll_lock = 0;
    @(negedge clk); ctl_nfc_clr = 0;
    rd(0, d); check("R10 nfc and pll cleared", d, 8'h40);
    check("R10 still no irq", irq, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_masked_pending();
        t_set_wins();
        t_no_glitch();
        t_tsv();
        t_ready();
        t_status_only();
      end
      begin
        repeat (20000) @(negedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule